// File: doc/BRIEF.md
# Byte-Wide Programmer Command Decoder

This block is the host-side register file of a programmer for byte-wide memory devices. A host writes to it through an 8-bit data bus and a 3-bit command code that can change at any time relative to the block clock. Between commands the code rests at the idle value `111`. To run a command, the host places a byte on the data bus, applies the command code, and then returns the code to idle. The command takes effect when the code is released, not when it is applied.

Three load commands fill a low address byte, a high address byte and a write-data byte. The two address bytes together drive a 16-bit device address. The write-data byte drives the device data pins, and a separate drive-enable output lets the pad ring place those pins in high impedance while the device is being read. Two mode commands set and clear that drive enable. Device read data comes back to the host four bits at a time: a select line picks which half appears on a 4-bit status bus, and the host merges the two halves into the full byte.

Top module: `prog_cmd_decoder`

## Requirements
- R1: After reset, `dev_addr` is 0x0000, `dev_wdata` is 0x00 and `dev_wdata_oe` is 0 (data pins in high impedance). This holds until the first command release.
- R2: Releasing code `000` (a change straight from `000` to `111`) loads `host_data` into `dev_addr[7:0]`.
- R3: Releasing code `001` loads `host_data` into `dev_addr[15:8]`.
- R4: Releasing code `010` loads `host_data` into `dev_wdata`.
- R5: A register loads on the third rising clock edge after the code returns to `111`, and it takes the `host_data` value present at the release. The register keeps its old value while the load code is held and through the first two edges after the release.
- R6: A load code that changes directly into another non-idle code loads nothing. Only the code present just before idle is acted on.
- R7: Releasing codes `100` or `110` changes none of `dev_addr`, `dev_wdata` and `dev_wdata_oe`. Releasing codes `011` or `101` leaves `dev_addr` and `dev_wdata` unchanged.
- R8: Releasing code `011` sets `dev_wdata_oe` to 1 (write mode). Releasing code `101` clears it to 0 (read mode).
- R9: `status_nib` equals `dev_rdata[3:0]` when `nib_sel` is 0 and `dev_rdata[7:4]` when `nib_sel` is 1. The path is combinational.
- R10: Every address from 0x0000 to 0xFFFF can be reached. `dev_addr` always equals {high byte, low byte}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_data | input | 8 | Host data byte. The host holds it stable from applying a code until a few cycles after releasing it |
| host_ctrl | input | 3 | Asynchronous command code. Idle is `111` |
| nib_sel | input | 1 | Readback half select: 0 for low nibble, 1 for high nibble |
| dev_rdata | input | 8 | Data read from the device data pins |
| dev_addr | output | 16 | Device address: {high byte, low byte} |
| dev_wdata | output | 8 | Write-data byte for the device data pins |
| dev_wdata_oe | output | 1 | Drive enable for the data pins. 0 means high impedance |
| status_nib | output | 4 | Selected nibble of `dev_rdata` |

## Verification
A command release takes effect on the third rising edge after the code returns to idle: two edges pass through the synchronizer and one edge loads the register. The nibble readback follows its inputs with no clock at all. The bench drives inputs on falling edges and reads outputs on falling edges. After each release it waits four falling edges before comparing, which is one edge more than the load needs. In the latency test it samples exactly after the second and after the third rising edge, to show the old value and then the new one. Each load target gets a full sweep of all 256 byte values, and every `dev_rdata` value is checked under both select settings.

// File: rtl/prog_cmd_pkg.sv
`timescale 1ns/1ps
package prog_cmd_pkg;
  localparam int CMD_W  = 3;
  localparam int NCODES = 1 << CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD_LO  = 3'b000,
    CMD_LOAD_HI  = 3'b001,
    CMD_LOAD_DAT = 3'b010,
    CMD_WR_MODE  = 3'b011,
    CMD_IDENT    = 3'b100,
    CMD_RD_MODE  = 3'b101,
    CMD_SPARE    = 3'b110,
    CMD_IDLE     = 3'b111
  } cmd_e;
endpackage

// File: rtl/cmd_sync.sv
`timescale 1ns/1ps
module cmd_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/cmd_release_detect.sv
`timescale 1ns/1ps
module cmd_release_detect
  import prog_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] code_sync,
  output logic [NCODES-2:0] rel_pulse
);
  logic [CMD_W-1:0] prev_q;
  logic [CMD_W-1:0] prev_d;
  logic             at_idle;

  assign at_idle = (code_sync == CMD_IDLE);
  assign prev_d  = code_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= CMD_IDLE;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NCODES-1; i++) begin : g_rel
    assign rel_pulse[i] = at_idle && (prev_q == CMD_W'(i));
  end
endmodule

// File: rtl/prog_regs.sv
`timescale 1ns/1ps
module prog_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_dat,
  input  logic              set_oe,
  input  logic              clr_oe,
  output logic [DATA_W-1:0] lo_byte,
  output logic [DATA_W-1:0] hi_byte,
  output logic [DATA_W-1:0] wdata,
  output logic              wdata_oe
);
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d, dat_q, dat_d;
  logic              oe_q, oe_d, oe_en;

  assign oe_en = set_oe | clr_oe;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    dat_d = dat_q;
    oe_d  = oe_q;
    if (ld_lo)  lo_d  = host_data;
    if (ld_hi)  hi_d  = host_data;
    if (ld_dat) dat_d = host_data;
    if (oe_en)  oe_d  = set_oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      dat_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      dat_q <= dat_d;
      oe_q  <= oe_d;
    end
  end

  assign lo_byte  = lo_q;
  assign hi_byte  = hi_q;
  assign wdata    = dat_q;
  assign wdata_oe = oe_q;
endmodule

// File: rtl/nibble_mux.sv
`timescale 1ns/1ps
module nibble_mux #(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] din,
  input  logic              sel_hi,
  output logic [NIB_W-1:0]  nib
);
  for (genvar i = 0; i < NIB_W; i++) begin : g_bit
    assign nib[i] = sel_hi ? din[i+NIB_W] : din[i];
  end
endmodule

// File: rtl/prog_cmd_decoder.sv
`timescale 1ns/1ps
module prog_cmd_decoder
  import prog_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int NIB_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_data,
  input  logic [CMD_W-1:0]  host_ctrl,
  input  logic              nib_sel,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_wdata_oe,
  output logic [NIB_W-1:0]  status_nib
);
  logic              rst_m_q, rst_s_q;
  logic [CMD_W-1:0]  code_s;
  logic [NCODES-2:0] rel;
  logic              ld_lo, ld_hi, ld_dat, set_oe, clr_oe;
  logic [1:0]        rel_unused;
  logic [DATA_W-1:0] lo_byte, hi_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  cmd_sync #(.W(CMD_W), .RST_VAL(CMD_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .d_async(host_ctrl), .q_sync(code_s)
  );

  cmd_release_detect u_rel (
    .clk(clk), .rst_n(rst_s_q), .code_sync(code_s), .rel_pulse(rel)
  );

  assign ld_lo      = rel[CMD_LOAD_LO];
  assign ld_hi      = rel[CMD_LOAD_HI];
  assign ld_dat     = rel[CMD_LOAD_DAT];
  assign set_oe     = rel[CMD_WR_MODE];
  assign clr_oe     = rel[CMD_RD_MODE];
  assign rel_unused = {rel[CMD_SPARE], rel[CMD_IDENT]};

  prog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_s_q), .host_data(host_data),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_dat(ld_dat),
    .set_oe(set_oe), .clr_oe(clr_oe),
    .lo_byte(lo_byte), .hi_byte(hi_byte),
    .wdata(dev_wdata), .wdata_oe(dev_wdata_oe)
  );

  assign dev_addr = {hi_byte, lo_byte};

  nibble_mux #(.DATA_W(DATA_W)) u_nib (
    .din(dev_rdata), .sel_hi(nib_sel), .nib(status_nib)
  );
endmodule

// File: rtl/prog_cmd_checker.sv
`timescale 1ns/1ps
module prog_cmd_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] host_data,
  input logic          ld_lo,
  input logic          ld_hi,
  input logic          ld_dat,
  input logic          set_oe,
  input logic          clr_oe,
  input logic [2*DW-1:0] dev_addr,
  input logic [DW-1:0] dev_wdata,
  input logic          dev_wdata_oe
);
  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> dev_addr[DW-1:0] == $past(host_data));
  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> dev_addr[2*DW-1:DW] == $past(host_data));
  p_dat_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dat |=> dev_wdata == $past(host_data));
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo || ld_hi || ld_dat) |=> !(ld_lo || ld_hi || ld_dat));
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_lo, ld_hi, ld_dat, set_oe, clr_oe}));
  p_lo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lo |=> $stable(dev_addr[DW-1:0]));
  p_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hi |=> $stable(dev_addr[2*DW-1:DW]));
  p_dat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_dat |=> $stable(dev_wdata));
  p_oe_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_oe |=> dev_wdata_oe);
  p_oe_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_oe |=> !dev_wdata_oe);
  p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_oe || clr_oe) |=> $stable(dev_wdata_oe));
endmodule

bind prog_cmd_decoder prog_cmd_checker #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_data(host_data),
  .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_dat(ld_dat),
  .set_oe(set_oe), .clr_oe(clr_oe),
  .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe)
);

// File: tb/prog_cmd_decoder_test.sv
`timescale 1ns/1ps
module prog_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = 8'h00;
  logic [2:0]  host_ctrl = 3'b111;
  logic        nib_sel = 1'b0;
  logic [7:0]  dev_rdata = 8'h00;
  logic [15:0] dev_addr;
  logic [7:0]  dev_wdata;
  logic        dev_wdata_oe;
  logic [3:0]  status_nib;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_lo = 8'h00, exp_hi = 8'h00, exp_dat = 8'h00;
  logic       exp_oe = 1'b0;

  always #10 clk = ~clk;

  prog_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_ctrl(host_ctrl),
    .nib_sel(nib_sel), .dev_rdata(dev_rdata), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe), .status_nib(status_nib)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, dev_addr, {exp_hi, exp_lo});
    check(req, {8'h00, dev_wdata}, {8'h00, exp_dat});
    check(req, {15'h0, dev_wdata_oe}, {15'h0, exp_oe});
  endtask

  task automatic run_cmd(input logic [2:0] code, input logic [7:0] data);
    @(negedge clk);
    host_data = data;
    host_ctrl = code;
    repeat (3) @(negedge clk);
    host_ctrl = 3'b111;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_all("R1");

    // R2 low address sweep
    for (int v = 0; v < 256; v++) begin
      run_cmd(3'b000, 8'(v));
      exp_lo = 8'(v);
      check("R2", dev_addr, {exp_hi, exp_lo});
    end
    // R3 high address sweep
    for (int v = 0; v < 256; v++) begin
      run_cmd(3'b001, 8'(255 - v));
      exp_hi = 8'(255 - v);
      check("R3", dev_addr, {exp_hi, exp_lo});
    end
    // R4 data sweep
    for (int v = 0; v < 256; v++) begin
      run_cmd(3'b010, 8'(v ^ 8'h5A));
      exp_dat = 8'(v ^ 8'h5A);
      check("R4", {8'h00, dev_wdata}, {8'h00, exp_dat});
    end
    check_all("R4");

    // R10 address range extremes
    run_cmd(3'b000, 8'hFF); exp_lo = 8'hFF;
    run_cmd(3'b001, 8'hFF); exp_hi = 8'hFF;
    check("R10", dev_addr, 16'hFFFF);
    run_cmd(3'b000, 8'h00); exp_lo = 8'h00;
    run_cmd(3'b001, 8'h00); exp_hi = 8'h00;
    check("R10", dev_addr, 16'h0000);

    // R5 capture on release, exact latency
    @(negedge clk);
    host_data = 8'hA5;
    host_ctrl = 3'b000;
    repeat (6) @(negedge clk);
    check("R5", dev_addr, {exp_hi, exp_lo});
    host_data = 8'h3C;
    @(negedge clk);
    host_ctrl = 3'b111;
    repeat (2) @(negedge clk);
    check("R5", dev_addr, {exp_hi, exp_lo});
    @(negedge clk);
    exp_lo = 8'h3C;
    check("R5", dev_addr, {exp_hi, exp_lo});
    repeat (3) @(negedge clk);

    // R6 load code changing directly into another load code
    @(negedge clk);
    host_data = 8'h11;
    host_ctrl = 3'b000;
    repeat (4) @(negedge clk);
    host_ctrl = 3'b001;
    repeat (4) @(negedge clk);
    host_ctrl = 3'b111;
    repeat (4) @(negedge clk);
    exp_hi = 8'h11;
    check_all("R6");

    // R7 codes without register effect
    run_cmd(3'b100, 8'hEE); check_all("R7");
    run_cmd(3'b110, 8'hEE); check_all("R7");
    // R8 mode codes drive enable
    run_cmd(3'b011, 8'hEE); exp_oe = 1'b1; check_all("R8");
    run_cmd(3'b100, 8'hDD); check_all("R7");
    run_cmd(3'b110, 8'hDD); check_all("R7");
    run_cmd(3'b101, 8'hEE); exp_oe = 1'b0; check_all("R8");
    run_cmd(3'b101, 8'hEE); check_all("R8");

    // R9 nibble readback, all values both halves
    for (int v = 0; v < 256; v++) begin
      dev_rdata = 8'(v);
      nib_sel = 1'b0;
      #1;
      check("R9", {12'h0, status_nib}, {12'h0, 4'(v & 15)});
      nib_sel = 1'b1;
      #1;
      check("R9", {12'h0, status_nib}, {12'h0, 4'(v >> 4)});
    end

    finish_run();
  end
endmodule